// File: doc/BRIEF.md
# USB Device Address Register with Deferred Commit

This block holds the device address of a USB device controller. Software reaches it as one 32-bit register over a simple write port, and its contents are always visible on a read-data output. The active 7-bit address goes straight to the packet-matching logic of the controller.

Software can change the address in two ways. In the immediate way, a write lands in the active address on the next clock. In the deferred way, software sets a control bit, called the pending bit here, when it writes the address. The new value then waits in a hidden staging register. The active address keeps answering until the status stage of the address-setting control transfer ends, which the controller signals as an acknowledged IN on endpoint 0. An OUT or SETUP on endpoint 0 drops the staged value instead. This lets firmware write the address early, and the hardware applies it at the moment the protocol requires.

A bus reset, or the block's own synchronous reset, returns everything to zero. Packet decoding, handshake generation and the timing rules for address changes are handled elsewhere in the controller.

Top module: `devaddr_reg`

## Requirements
- R1: After `rst` is held high across a clock edge, `dev_addr` is 0 and `reg_rdata` is 0.
- R2: `reg_rdata` carries the active address in bits 31:25 and the pending bit in bit 24. Bits 23:0 always read 0, whatever was written to them. The staged value never appears on `reg_rdata`.
- R3: A write with bit 24 = 0 while the pending bit is clear loads `reg_wdata[31:25]` into `dev_addr` on the next clock, and the pending bit stays clear.
- R4: A write with bit 24 = 1 stores `reg_wdata[31:25]` in the staging register and sets the pending bit. `dev_addr` does not change.
- R5: An `ep0_in_ack` strobe while the pending bit is set copies the staged value into `dev_addr` and clears the pending bit.
- R6: An `ep0_out` or `ep0_setup` strobe while the pending bit is set clears the pending bit and leaves `dev_addr` unchanged. The staged value is discarded, so a later `ep0_in_ack` has no effect.
- R7: While the pending bit is set, a write with bit 24 = 0 does not clear it. The write's address replaces the staged value, and `dev_addr` does not change.
- R8: `bus_rst` clears the pending bit and forces `dev_addr` to 0 on the next clock. It takes priority over any write or endpoint-0 event in the same cycle.
- R9: When a write and an endpoint-0 event arrive in the same cycle, the event is applied to the state first, and the write is then applied to the result.
- R10: Endpoint-0 strobes have no effect while the pending bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | Single-cycle pulse marking a USB bus reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| ep0_in_ack | input | 1 | Strobe: an IN on endpoint 0 was acknowledged |
| ep0_out | input | 1 | Strobe: an OUT was received on endpoint 0 |
| ep0_setup | input | 1 | Strobe: a SETUP was received on endpoint 0 |
| dev_addr | output | 7 | Active device address |
| reg_rdata | output | 32 | Register read value |

## Verification
The checker assumes that the endpoint-0 strobes, `bus_rst` and `reg_wr` are synchronous to `clk` and are sampled only at the clock edge. It also assumes that the only state it can observe is the active address and the pending bit on the read port. Its properties therefore guard on the pending bit as read back, and they do not predict the staged value. The stimulus changes every input only at the falling edge, and it holds each strobe for exactly one cycle. It deliberately combines strobes with writes and resets in the same cycle, so the checks cover the ordering rules at the ports, not only in the checker.

// File: rtl/devaddr_pkg.sv
package devaddr_pkg;

    localparam int REG_W   = 32;
    localparam int ADR_W   = 7;
    localparam int ADR_LSB = 25;
    localparam int PEND_POS = 24;

    typedef logic [ADR_W-1:0] dev_adr_t;

    typedef struct packed {
        dev_adr_t active;
        dev_adr_t staged;
        logic     pending;
    } adr_state_t;

    typedef struct packed {
        logic in_ack;
        logic out_rx;
        logic setup_rx;
    } ep0_evt_t;

    typedef struct packed {
        logic     valid;
        dev_adr_t addr;
        logic     defer;
    } adr_write_t;

    localparam adr_state_t STATE_RESET = '{active: '0, staged: '0, pending: 1'b0};

    function automatic logic [REG_W-1:0] pack_read(dev_adr_t a, logic p);
        logic [REG_W-1:0] r;
        r = '0;
        r[ADR_LSB +: ADR_W] = a;
        r[PEND_POS]         = p;
        return r;
    endfunction

endpackage

// File: rtl/devaddr_evt_resolve.sv
module devaddr_evt_resolve
    import devaddr_pkg::*;
(
    input  adr_state_t cur,
    input  ep0_evt_t   evt,
    output adr_state_t nxt
);
    always_comb begin
        nxt = cur;
        if (cur.pending) begin
            if (evt.in_ack) begin
                nxt.active  = cur.staged;
                nxt.pending = 1'b0;
            end else if (evt.out_rx || evt.setup_rx) begin
                nxt.pending = 1'b0;
            end
        end
    end
endmodule

// File: rtl/devaddr_wr_apply.sv
module devaddr_wr_apply
    import devaddr_pkg::*;
(
    input  adr_state_t cur,
    input  adr_write_t wr,
    output adr_state_t nxt
);
    always_comb begin
        nxt = cur;
        if (wr.valid) begin
            if (wr.defer || cur.pending) begin
                nxt.staged  = wr.addr;
                nxt.pending = 1'b1;
            end else begin
                nxt.active = wr.addr;
            end
        end
    end
endmodule

// File: rtl/devaddr_reg.sv
module devaddr_reg
    import devaddr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             ep0_in_ack,
    input  logic             ep0_out,
    input  logic             ep0_setup,
    output logic [ADR_W-1:0] dev_addr,
    output logic [REG_W-1:0] reg_rdata
);
    adr_state_t state_q;
    adr_state_t after_evt;
    adr_state_t after_wr;
    ep0_evt_t   evt;
    adr_write_t wr;
    logic       unused_low_bits;

    assign evt = '{in_ack: ep0_in_ack, out_rx: ep0_out, setup_rx: ep0_setup};
    assign wr  = '{valid: reg_wr,
                   addr:  reg_wdata[ADR_LSB +: ADR_W],
                   defer: reg_wdata[PEND_POS]};
    assign unused_low_bits = ^reg_wdata[PEND_POS-1:0];

    // endpoint events resolve first, the register write lands on the result
    devaddr_evt_resolve evt_i (
        .cur (state_q),
        .evt (evt),
        .nxt (after_evt)
    );

    devaddr_wr_apply wr_i (
        .cur (after_evt),
        .wr  (wr),
        .nxt (after_wr)
    );

    always_ff @(posedge clk) begin
        if (rst || bus_rst) begin
            state_q <= STATE_RESET;
        end else begin
            state_q <= after_wr;
        end
    end

    assign dev_addr  = state_q.active;
    assign reg_rdata = pack_read(state_q.active, state_q.pending);

endmodule

// File: rtl/devaddr_reg_chk.sv
module devaddr_reg_chk
    import devaddr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_rst,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic             ep0_in_ack,
    input logic             ep0_out,
    input logic             ep0_setup,
    input logic [ADR_W-1:0] dev_addr,
    input logic [REG_W-1:0] reg_rdata
);
    logic     pend;
    dev_adr_t wadr;
    logic     unused_chk;

    assign pend = reg_rdata[PEND_POS];
    assign wadr = reg_wdata[ADR_LSB +: ADR_W];
    assign unused_chk = ^reg_wdata[PEND_POS-1:0];

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[PEND_POS-1:0] == '0);

    p_addr_mirror_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[ADR_LSB +: ADR_W] == dev_addr);

    p_immediate_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[PEND_POS] && !pend && !bus_rst)
        |=> (dev_addr == $past(wadr)) && !reg_rdata[PEND_POS]);

    p_defer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[PEND_POS] && !(pend && ep0_in_ack) && !bus_rst)
        |=> $stable(dev_addr) && reg_rdata[PEND_POS]);

    p_discard_r6: assert property (@(posedge clk) disable iff (rst)
        (pend && (ep0_out || ep0_setup) && !ep0_in_ack && !reg_wr && !bus_rst)
        |=> $stable(dev_addr) && !reg_rdata[PEND_POS]);

    p_no_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && reg_wr && !ep0_in_ack && !ep0_out && !ep0_setup && !bus_rst)
        |=> $stable(dev_addr) && reg_rdata[PEND_POS]);

    p_bus_reset_r8: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (dev_addr == '0) && !reg_rdata[PEND_POS]);

    p_idle_events_r10: assert property (@(posedge clk) disable iff (rst)
        (!pend && !reg_wr && !bus_rst) |=> $stable(dev_addr) && !reg_rdata[PEND_POS]);

endmodule

bind devaddr_reg devaddr_reg_chk chk_i (.*);

// File: tb/devaddr_reg_tb_top.sv
`timescale 1ns/1ps
module devaddr_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_rst;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic        ep0_in_ack, ep0_out, ep0_setup;
    logic [6:0]  dev_addr;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    devaddr_reg dut_i (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .ep0_in_ack(ep0_in_ack), .ep0_out(ep0_out),
        .ep0_setup(ep0_setup), .dev_addr(dev_addr), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic       br;
        logic       wr;
        logic [6:0] a;
        logic       adv;
        logic       in_a;
        logic       out_r;
        logic       su;
        logic [6:0] ea;
        logic       ev;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,7'h05,1'b0,1'b0,1'b0,1'b0,7'h05,1'b0,4'd3},  // R3 immediate
        '{1'b0,1'b1,7'h12,1'b1,1'b0,1'b0,1'b0,7'h05,1'b1,4'd4},  // R4 staged
        '{1'b0,1'b0,7'h00,1'b0,1'b0,1'b0,1'b0,7'h05,1'b1,4'd4},  // R4 holds
        '{1'b0,1'b1,7'h13,1'b0,1'b0,1'b0,1'b0,7'h05,1'b1,4'd7},  // R7 no cancel
        '{1'b0,1'b0,7'h00,1'b0,1'b1,1'b0,1'b0,7'h13,1'b0,4'd5},  // R5 commit
        '{1'b0,1'b0,7'h00,1'b0,1'b1,1'b0,1'b0,7'h13,1'b0,4'd10}, // R10 IN ignored
        '{1'b0,1'b0,7'h00,1'b0,1'b0,1'b1,1'b0,7'h13,1'b0,4'd10}, // R10 OUT ignored
        '{1'b0,1'b1,7'h20,1'b1,1'b0,1'b0,1'b0,7'h13,1'b1,4'd4},
        '{1'b0,1'b0,7'h00,1'b0,1'b0,1'b0,1'b1,7'h13,1'b0,4'd6},  // R6 SETUP drops
        '{1'b0,1'b1,7'h21,1'b1,1'b0,1'b0,1'b0,7'h13,1'b1,4'd4},
        '{1'b0,1'b0,7'h00,1'b0,1'b0,1'b1,1'b0,7'h13,1'b0,4'd6},  // R6 OUT drops
        '{1'b0,1'b0,7'h00,1'b0,1'b1,1'b0,1'b0,7'h13,1'b0,4'd6},  // R6 stage gone
        '{1'b0,1'b1,7'h30,1'b1,1'b0,1'b0,1'b0,7'h13,1'b1,4'd4},
        '{1'b0,1'b1,7'h40,1'b0,1'b1,1'b0,1'b0,7'h40,1'b0,4'd9},  // R9 commit then write
        '{1'b0,1'b1,7'h41,1'b1,1'b0,1'b0,1'b0,7'h40,1'b1,4'd4},
        '{1'b0,1'b1,7'h42,1'b1,1'b0,1'b1,1'b0,7'h40,1'b1,4'd9},  // R9 drop then restage
        '{1'b0,1'b0,7'h00,1'b0,1'b1,1'b0,1'b0,7'h42,1'b0,4'd5},  // R5 new stage
        '{1'b0,1'b1,7'h55,1'b1,1'b0,1'b0,1'b0,7'h42,1'b1,4'd4},
        '{1'b1,1'b0,7'h00,1'b0,1'b1,1'b0,1'b0,7'h00,1'b0,4'd8},  // R8 beats IN
        '{1'b0,1'b0,7'h00,1'b0,1'b1,1'b0,1'b0,7'h00,1'b0,4'd8},  // R8 pending gone
        '{1'b0,1'b1,7'h7F,1'b0,1'b0,1'b0,1'b0,7'h7F,1'b0,4'd3},  // R3 max address
        '{1'b1,1'b1,7'h11,1'b0,1'b0,1'b0,1'b0,7'h00,1'b0,4'd8}   // R8 beats write
    };

    task automatic check(input logic [6:0] ea, input logic ev, input int req, input string tag);
        logic [31:0] er;
        er = {ea, ev, 24'h0};
        checks++;
        if (dev_addr !== ea || reg_rdata !== er) begin
            fails++;
            $display("FAIL %s R%0d: addr=%h rdata=%h expected addr=%h rdata=%h",
                     tag, req, dev_addr, reg_rdata, ea, er);
        end
    endtask

    task automatic idle_inputs();
        bus_rst = 0; reg_wr = 0; reg_wdata = '0;
        ep0_in_ack = 0; ep0_out = 0; ep0_setup = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        check(7'h00, 1'b0, 1, "reset state R1");

        for (int i = 0; i < NV; i++) begin
            bus_rst    = VECS[i].br;
            reg_wr     = VECS[i].wr;
            // low bits written as ones: R2 says they always read 0
            reg_wdata  = {VECS[i].a, VECS[i].adv, 24'hFFFFFF};
            ep0_in_ack = VECS[i].in_a;
            ep0_out    = VECS[i].out_r;
            ep0_setup  = VECS[i].su;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            check(VECS[i].ea, VECS[i].ev, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R2: staged value stays hidden while pending
        reg_wr = 1; reg_wdata = {7'h66, 1'b0, 24'h0};
        @(posedge clk); @(negedge clk); idle_inputs();
        check(7'h66, 1'b0, 2, "immediate before stage R2");
        reg_wr = 1; reg_wdata = {7'h1A, 1'b1, 24'h0};
        @(posedge clk); @(negedge clk); idle_inputs();
        check(7'h66, 1'b1, 2, "staged value hidden R2");

        // R1: synchronous reset while pending
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        check(7'h00, 1'b0, 1, "reset while pending R1");
        ep0_in_ack = 1;
        @(posedge clk); @(negedge clk); idle_inputs();
        check(7'h00, 1'b0, 1, "no commit after reset R1");

        finish_run();
    end
endmodule